// File: doc/BRIEF.md
# Select-Stream Steering Tree Node

This block is one interior node of a binary tree memory whose words sit at the leaves. The node forwards a serial address/data stream from its parent to both children. It also passes a serial select run to exactly one child. The child is chosen by the address bit present on the first cycle of the select run. On the way back, the node ORs the two children's serial data-out lines into one line toward its parent.

Every node applies one register stage to each of its three paths, so a tree built from identical nodes has the same return latency from every leaf. Each node drops the leading bit of the select run it passes on. The forwarded address/data stream has already shifted by one cycle, so the next address bit lines up with the first bit of the shortened run at the child. Because of this alignment, the node needs no level-dependent decoding: the bit under the run's head is always the one that belongs to this level.

Steering is done by a small stateful gate per child rather than an address decoder. A majority of three terms decides each cycle: the incoming select, a start term, and a continue term. The resulting decision is held for as long as the select run lasts.

Top module: `seltree_node`

## Requirements
- R1: While the reset input is low, every output (both forwarded streams, both child selects, merged data-out) is 0, whatever the inputs do.
- R2: Each forwarded address/data output equals the address/data input of the previous cycle, on all lanes and for both children.
- R3: The direction of a select run is fixed by lane 0 of the address/data input on the run's first cycle: value 0 picks the left child, value 1 picks the right child.
- R4: For an input run that is high on cycles t to t+L-1, the chosen child's select is high exactly in the L-1 output windows that follow the clock edges of cycles t+1 to t+L-1. It is never high unless the input select was high in both of the two preceding cycles.
- R5: Once a run has started, address bits arriving during the rest of the run do not change its direction.
- R6: At most one child select is high in any cycle.
- R7: Two cycles after the input select is low, both child selects are low.
- R8: A select run one cycle long produces no select on either child.
- R9: Runs separated by a single idle cycle are steered independently, each by its own first-cycle address bit.
- R10: The merged data-out equals the bitwise OR of the two children's data-out lines of the previous cycle.
- R11: While the input select stays low, no address/data pattern raises either child select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| pkt_in | input | LANE_W | Serial address/data stream from the parent; lane 0 carries address bits |
| sel_in | input | 1 | Serial select stream from the parent |
| pkt_to_l | output | LANE_W | Address/data stream forwarded to the left child |
| pkt_to_r | output | LANE_W | Address/data stream forwarded to the right child |
| sel_to_l | output | 1 | Select stream to the left child |
| sel_to_r | output | 1 | Select stream to the right child |
| dout_l | input | LANE_W | Serial data-out from the left child |
| dout_r | input | LANE_W | Serial data-out from the right child |
| dout_up | output | LANE_W | Merged data-out toward the parent |

## Verification
Several properties are checked on every cycle: the one-cycle forwarding of the address/data stream and of the merged data-out, mutual exclusion of the child selects, the two-cycle ancestry and shutoff of any child select, and the direction chosen at a run's head. Persistence of a started run against changing address bits is also checked every cycle. Only the directed scenarios show the exact length of a forwarded run. The same holds for the suppression of one-cycle runs, independent steering of runs split by a single idle cycle, and the behaviour of the outputs during reset.

// File: rtl/seltree_pkg.sv
package seltree_pkg;

  // Which child a steering gate serves; the value is the address bit that selects it.
  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } child_dir_e;

  localparam int NUM_CHILD = 2;

endpackage

// File: rtl/seltree_rst_sync.sv
module seltree_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/seltree_steer.sv
module seltree_steer
  import seltree_pkg::*;
#(
  parameter child_dir_e DIR = DIR_LEFT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_in,
  input  logic sel_prev,
  input  logic addr_bit,
  output logic sel_out
);

  logic gate_q;
  logic gate_d;
  logic out_d;
  logic start_t;
  logic cont_t;

  always_comb begin
    // start: the run begins now and the address bit points at this child
    start_t = !sel_prev && (addr_bit == logic'(DIR));
    // continue: this child already owns the run and the run is still going
    cont_t  = sel_in && gate_q;
    gate_d  = (sel_in && start_t) || (sel_in && cont_t) || (start_t && cont_t);
    // hide the head bit of the run: pass only once the previous select was high
    out_d   = gate_d && sel_prev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= 1'b0;
      sel_out <= 1'b0;
    end else begin
      gate_q  <= gate_d;
      sel_out <= out_d;
    end
  end

endmodule

// File: rtl/seltree_fwd.sv
module seltree_fwd #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] nxt;

  always_comb begin
    nxt = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else begin
      dout <= nxt;
    end
  end

endmodule

// File: rtl/seltree_merge.sv
module seltree_merge #(
  parameter int W = 1,
  parameter int N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0][W-1:0] lines,
  output logic [W-1:0]        merged
);

  logic [W-1:0] nxt;

  always_comb begin
    nxt = '0;
    for (int i = 0; i < N; i++) begin
      nxt = nxt | lines[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      merged <= '0;
    end else begin
      merged <= nxt;
    end
  end

endmodule

// File: rtl/seltree_node.sv
module seltree_node
  import seltree_pkg::*;
#(
  parameter int LANE_W    = 2,
  parameter int ADDR_LANE = 0,
  parameter int RST_SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] pkt_in,
  input  logic              sel_in,
  output logic [LANE_W-1:0] pkt_to_l,
  output logic [LANE_W-1:0] pkt_to_r,
  output logic              sel_to_l,
  output logic              sel_to_r,
  input  logic [LANE_W-1:0] dout_l,
  input  logic [LANE_W-1:0] dout_r,
  output logic [LANE_W-1:0] dout_up
);

  localparam int NC = NUM_CHILD;

  logic                    rst_n_int;
  logic                    sel_prev_q;
  logic                    sel_prev_d;
  logic [NC-1:0][LANE_W-1:0] pkt_fwd;
  logic [NC-1:0]             sel_fwd;
  logic [NC-1:0][LANE_W-1:0] dout_child;

  seltree_rst_sync #(.STAGES(RST_SYNC)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // previous input select, shared by both steering gates
  always_comb begin
    sel_prev_d = sel_in;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      sel_prev_q <= 1'b0;
    end else begin
      sel_prev_q <= sel_prev_d;
    end
  end

  generate
    for (genvar gi = 0; gi < NC; gi++) begin : g_child
      seltree_fwd #(.W(LANE_W)) i_fwd (
        .clk   (clk),
        .rst_n (rst_n_int),
        .din   (pkt_in),
        .dout  (pkt_fwd[gi])
      );

      seltree_steer #(.DIR(gi == 0 ? DIR_LEFT : DIR_RIGHT)) i_steer (
        .clk      (clk),
        .rst_n    (rst_n_int),
        .sel_in   (sel_in),
        .sel_prev (sel_prev_q),
        .addr_bit (pkt_in[ADDR_LANE]),
        .sel_out  (sel_fwd[gi])
      );
    end
  endgenerate

  assign dout_child[0] = dout_l;
  assign dout_child[1] = dout_r;

  seltree_merge #(.W(LANE_W), .N(NC)) i_merge (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .lines  (dout_child),
    .merged (dout_up)
  );

  assign pkt_to_l = pkt_fwd[0];
  assign pkt_to_r = pkt_fwd[1];
  assign sel_to_l = sel_fwd[0];
  assign sel_to_r = sel_fwd[1];

endmodule

// File: rtl/seltree_node_chk.sv
module seltree_node_chk #(
  parameter int LANE_W    = 2,
  parameter int ADDR_LANE = 0
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [LANE_W-1:0] pkt_in,
  input logic              sel_in,
  input logic [LANE_W-1:0] pkt_to_l,
  input logic [LANE_W-1:0] pkt_to_r,
  input logic              sel_to_l,
  input logic              sel_to_r,
  input logic [LANE_W-1:0] dout_l,
  input logic [LANE_W-1:0] dout_r,
  input logic [LANE_W-1:0] dout_up
);

  // cycles since internal reset release, saturating at 2
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      age <= 2'd0;
    end else if (age != 2'd2) begin
      age <= age + 2'd1;
    end
  end

  // R2
  fwd_pkt_chk: assert property (@(posedge clk) disable iff (!rst_int_n || age == 2'd0)
    (pkt_to_l == $past(pkt_in)) && (pkt_to_r == $past(pkt_in)));

  // R10
  merge_or_chk: assert property (@(posedge clk) disable iff (!rst_int_n || age == 2'd0)
    dout_up == ($past(dout_l) | $past(dout_r)));

  // R6
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({sel_to_l, sel_to_r}));

  // R4
  sel_origin_chk: assert property (@(posedge clk) disable iff (!rst_int_n || age != 2'd2)
    (sel_to_l || sel_to_r) |-> ($past(sel_in) && $past(sel_in, 2)));

  // R7
  sel_stop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !sel_in |=> ##1 !(sel_to_l || sel_to_r));

  // R3
  dir_left_chk: assert property (@(posedge clk) disable iff (!rst_int_n || age != 2'd2)
    (sel_in && $past(sel_in) && !$past(sel_in, 2) && !$past(pkt_in[ADDR_LANE])) |=> sel_to_l);

  // R3
  dir_right_chk: assert property (@(posedge clk) disable iff (!rst_int_n || age != 2'd2)
    (sel_in && $past(sel_in) && !$past(sel_in, 2) && $past(pkt_in[ADDR_LANE])) |=> sel_to_r);

  // R5
  hold_left_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_to_l && sel_in) |=> sel_to_l);

  // R5
  hold_right_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_to_r && sel_in) |=> sel_to_r);

endmodule

bind seltree_node seltree_node_chk #(.LANE_W(LANE_W), .ADDR_LANE(ADDR_LANE)) i_chk (
  .clk       (clk),
  .rst_int_n (rst_n_int),
  .pkt_in    (pkt_in),
  .sel_in    (sel_in),
  .pkt_to_l  (pkt_to_l),
  .pkt_to_r  (pkt_to_r),
  .sel_to_l  (sel_to_l),
  .sel_to_r  (sel_to_r),
  .dout_l    (dout_l),
  .dout_r    (dout_r),
  .dout_up   (dout_up)
);

// File: tb/test_seltree_node.sv
module test_seltree_node;

  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [LW-1:0] pkt_in;
  logic          sel_in;
  logic [LW-1:0] pkt_to_l, pkt_to_r;
  logic          sel_to_l, sel_to_r;
  logic [LW-1:0] dout_l, dout_r, dout_up;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic          s_sel[64];
  logic [LW-1:0] s_pkt[64];
  logic [LW-1:0] s_dl[64];
  logic [LW-1:0] s_dr[64];
  int            n;

  always #5ns clk = ~clk;

  seltree_node #(.LANE_W(LW), .ADDR_LANE(0)) i_seltree_node (
    .clk      (clk),
    .rst_n    (rst_n),
    .pkt_in   (pkt_in),
    .sel_in   (sel_in),
    .pkt_to_l (pkt_to_l),
    .pkt_to_r (pkt_to_r),
    .sel_to_l (sel_to_l),
    .sel_to_r (sel_to_r),
    .dout_l   (dout_l),
    .dout_r   (dout_r),
    .dout_up  (dout_up)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    n = 0;
  endtask

  task automatic push(input logic s, input logic [LW-1:0] p, input logic [LW-1:0] dl,
                      input logic [LW-1:0] dr);
    s_sel[n] = s;
    s_pkt[n] = p;
    s_dl[n]  = dl;
    s_dr[n]  = dr;
    n++;
  endtask

  task automatic idle(input int cnt);
    for (int i = 0; i < cnt; i++) push(1'b0, 2'b00, 2'b00, 2'b00);
  endtask

  // Drive the recorded sequence; check each output window against the requirements.
  task automatic play(input string tag);
    logic run_dir;
    logic prev_s;
    logic exp_l, exp_r;
    run_dir = 1'b0;
    prev_s  = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sel_in = s_sel[k];
      pkt_in = s_pkt[k];
      dout_l = s_dl[k];
      dout_r = s_dr[k];
      @(posedge clk);
      #1ns;
      if (s_sel[k] && !prev_s) run_dir = s_pkt[k][0];
      exp_l = s_sel[k] && prev_s && !run_dir;
      exp_r = s_sel[k] && prev_s && run_dir;
      chk(sel_to_l === exp_l, {tag, " left select"}, int'(sel_to_l), int'(exp_l));
      chk(sel_to_r === exp_r, {tag, " right select"}, int'(sel_to_r), int'(exp_r));
      chk(!(sel_to_l && sel_to_r), "R6 both selects", int'({sel_to_l, sel_to_r}), 0);
      chk(pkt_to_l === s_pkt[k] && pkt_to_r === s_pkt[k], "R2 forward",
          int'({pkt_to_l, pkt_to_r}), int'({s_pkt[k], s_pkt[k]}));
      chk(dout_up === (s_dl[k] | s_dr[k]), "R10 merge", int'(dout_up), int'(s_dl[k] | s_dr[k]));
      prev_s = s_sel[k];
    end
  endtask

  task automatic t_reset();
    rst_n  = 1'b0;
    sel_in = 1'b1;
    pkt_in = 2'b11;
    dout_l = 2'b11;
    dout_r = 2'b10;
    repeat (3) @(posedge clk);
    #1ns;
    chk(sel_to_l === 1'b0 && sel_to_r === 1'b0, "R1 selects in reset",
        int'({sel_to_l, sel_to_r}), 0);
    chk(pkt_to_l === '0 && pkt_to_r === '0, "R1 forward in reset",
        int'({pkt_to_l, pkt_to_r}), 0);
    chk(dout_up === '0, "R1 merge in reset", int'(dout_up), 0);
    @(negedge clk);
    sel_in = 1'b0;
    pkt_in = '0;
    dout_l = '0;
    dout_r = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // R3 R4 R7: left run of four, later address bits wander
  task automatic t_left_run();
    clr();
    idle(2);
    push(1'b1, 2'b10, 2'b01, 2'b00);
    push(1'b1, 2'b01, 2'b00, 2'b10);
    push(1'b1, 2'b11, 2'b01, 2'b10);
    push(1'b1, 2'b01, 2'b00, 2'b00);
    idle(3);
    play("R3 R4 R7 left run");
  endtask

  // R3 R5: right run of six with later address bits at 0
  task automatic t_right_hold();
    clr();
    idle(1);
    push(1'b1, 2'b01, 2'b00, 2'b00);
    for (int i = 0; i < 5; i++) push(1'b1, 2'b00, 2'b10, 2'b01);
    idle(3);
    play("R3 R5 right hold");
  endtask

  // R8: one-cycle runs in both directions
  task automatic t_single();
    clr();
    idle(1);
    push(1'b1, 2'b00, 2'b00, 2'b00);
    idle(3);
    push(1'b1, 2'b01, 2'b00, 2'b00);
    idle(3);
    play("R8 single cycle");
  endtask

  // R9: runs split by one idle cycle, alternating direction
  task automatic t_back2back();
    clr();
    idle(1);
    push(1'b1, 2'b00, 2'b00, 2'b00);
    push(1'b1, 2'b01, 2'b00, 2'b00);
    push(1'b1, 2'b01, 2'b00, 2'b00);
    idle(1);
    push(1'b1, 2'b01, 2'b00, 2'b00);
    push(1'b1, 2'b00, 2'b00, 2'b00);
    push(1'b1, 2'b00, 2'b00, 2'b00);
    idle(1);
    push(1'b1, 2'b00, 2'b00, 2'b00);
    push(1'b1, 2'b01, 2'b00, 2'b00);
    idle(3);
    play("R9 back to back");
  endtask

  // R11 R10: select held low, address toggles, all merge combinations
  task automatic t_idle_toggle();
    clr();
    for (int i = 0; i < 16; i++) push(1'b0, LW'(i), LW'(i >> 2), LW'(i));
    idle(2);
    play("R11 idle toggle");
  endtask

  initial begin
    #1ms;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_left_run();
    t_right_hold();
    t_single();
    t_back2back();
    t_idle_toggle();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule